// File: doc/BRIEF.md
# Shadow Configuration Load Handshake

This block holds controller settings in two layers. Software writes staging registers in the register-bus clock domain: a master configuration word, a clock divisor word, a slave configuration word and a timeout configuration word. None of these values reaches the controller core until software sets the matching bit in a load register. The block then carries the staged group across into the core clock domain and writes it into the active registers.

Each of the three groups has its own request toggle. The toggle passes through a synchronizer into the core clock. The core copies the group's staged words into its active registers on a single core edge and flips an acknowledge toggle. That acknowledge passes through a synchronizer back to the bus side. A load bit reads 1 from the bus cycle after it is set until the acknowledge returns, and then it clears by itself. Software polls the load register until it reads zero and gives up after a bounded wait.

The staged words of a group are frozen while that group's load is pending. The core therefore always samples a multi-bit value that does not move. The decoded master fields are driven from the active registers for use by the downstream controller logic.

Top module: `cfg_shadow_loader`

## Requirements
- R1: After reset, every active register, every decoded field and the load status read zero.
- R2: A write to a staging register (address 0 master configuration, 1 clock divisor, 2 slave configuration, 3 timeout configuration) leaves the active outputs unchanged until the load bit of its group is set.
- R3: Writing 1 to bit g of the load register (address 4) while that bit is clear makes `load_status[g]` read 1 from the next bus cycle on. The bit returns to 0 without further writes once the group's values are active.
- R4: A master load (bit 0) makes the core present, all on the same core edge, packet-mode enable from configuration bit 10, new-FSM select from bit 11, the 3-bit debounce count from bits 14:12, multi-master enable from bit 17, the high-speed divisor from divisor bits 15:0 and the standard/fast divisor from divisor bits 31:16.
- R5: The groups are independent. Bit 0 loads the master configuration together with the divisor, bit 1 loads the slave word and bit 2 loads the timeout word. A load of one group never changes another group's active values, and several bits may be set in one write.
- R6: Writing 1 to a load bit that is already pending is ignored, and writing 0 to a load bit has no effect, whether the bit is pending or idle.
- R7: A staging write to a group whose load is pending is discarded, so the values that become active are those staged before the load bit was set.
- R8: By the time a load bit reads 0 again, the group's active outputs already hold the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register-bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| load_status | output | 3 | Pending load bits (bit 0 master, 1 slave, 2 timeout) |
| clk_core | input | 1 | Controller core clock |
| rst_core | input | 1 | Synchronous active-high reset, core domain |
| act_pkt_mode | output | 1 | Active packet-mode enable |
| act_new_fsm | output | 1 | Active new-FSM select |
| act_debounce | output | 3 | Active debounce count |
| act_multi_master | output | 1 | Active multi-master enable |
| act_div_hs | output | 16 | Active high-speed divisor |
| act_div_std | output | 16 | Active standard/fast divisor |
| act_mst_cfg | output | 32 | Active master configuration word |
| act_slv_cfg | output | 32 | Active slave configuration word |
| act_tmo_cfg | output | 32 | Active timeout configuration word |

## Verification
The assertions check four things on every cycle. A load bit sets in the cycle after an accepted request. A repeated request never disturbs the request toggle. Staging words of a pending group hold still. The active words of a group change only on the core edge that flips its acknowledge, which shows the update is atomic. Only the bench scenarios can show the rest: that the right bit fields arrive in each decoded output, that a load bit clears by itself after the round trip, that values are already active when the bit reads zero, and that a discarded staging write is really absent after a later reload.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int NUM_GRP = 3;
    localparam int NUM_REG = 4;

    // register map: staging words at their index, load register after them
    localparam logic [ADDR_W-1:0] ADDR_LOAD = ADDR_W'(NUM_REG);

    // master configuration field positions
    localparam int PKT_BIT = 10;
    localparam int FSM_BIT = 11;
    localparam int DEB_LSB = 12;
    localparam int DEB_W   = 3;
    localparam int MM_BIT  = 17;
    localparam int DIV_W   = 16;
    localparam int DIV_STD_LSB = 16;

    typedef enum int {
        GRP_MST = 0,
        GRP_SLV = 1,
        GRP_TMO = 2
    } grp_e;

    typedef struct packed {
        logic              pkt_mode;
        logic              new_fsm;
        logic [DEB_W-1:0]  debounce;
        logic              multi_master;
        logic [DIV_W-1:0]  div_hs;
        logic [DIV_W-1:0]  div_std;
    } mst_fields_t;

    // which load group owns each staging register
    function automatic int grp_of_reg(input int idx);
        case (idx)
            0, 1:    return int'(GRP_MST);
            2:       return int'(GRP_SLV);
            default: return int'(GRP_TMO);
        endcase
    endfunction

    function automatic mst_fields_t decode_mst(input logic [DATA_W-1:0] cfg,
                                               input logic [DATA_W-1:0] div);
        mst_fields_t f;
        f.pkt_mode     = cfg[PKT_BIT];
        f.new_fsm      = cfg[FSM_BIT];
        f.debounce     = cfg[DEB_LSB +: DEB_W];
        f.multi_master = cfg[MM_BIT];
        f.div_hs       = div[DIV_W-1:0];
        f.div_std      = div[DIV_STD_LSB +: DIV_W];
        return f;
    endfunction

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgld_bus_side.sv
module cfgld_bus_side
    import cfgld_pkg::*;
(
    input  logic                            clk_bus,
    input  logic                            rst_bus,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic [NUM_GRP-1:0]              ack_s,
    output logic [NUM_GRP-1:0]              req_tgl,
    output logic [NUM_GRP-1:0]              load_status,
    output logic [NUM_REG-1:0][DATA_W-1:0]  stg_regs
);
    logic load_wr;

    assign load_wr     = wr_en && (wr_addr == ADDR_LOAD);
    // a group is pending while its request and returned acknowledge differ
    assign load_status = req_tgl ^ ack_s;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_req
        always_ff @(posedge clk_bus) begin
            if (rst_bus)
                req_tgl[g] <= 1'b0;
            else if (load_wr && wr_data[g] && !load_status[g])
                req_tgl[g] <= ~req_tgl[g];
        end
    end

    for (genvar i = 0; i < NUM_REG; i++) begin : g_stg
        localparam int G = grp_of_reg(i);
        always_ff @(posedge clk_bus) begin
            if (rst_bus)
                stg_regs[i] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(i)) && !load_status[G])
                stg_regs[i] <= wr_data;
        end
    end
endmodule

// File: rtl/cfgld_core_side.sv
module cfgld_core_side
    import cfgld_pkg::*;
(
    input  logic                            clk_core,
    input  logic                            rst_core,
    input  logic [NUM_GRP-1:0]              req_s,
    input  logic [NUM_REG-1:0][DATA_W-1:0]  stg_regs,
    output logic [NUM_REG-1:0][DATA_W-1:0]  act_regs,
    output logic [NUM_GRP-1:0]              ack_tgl
);
    logic [NUM_GRP-1:0] seen;
    logic [NUM_GRP-1:0] take;

    assign take    = req_s ^ seen;
    assign ack_tgl = seen;

    always_ff @(posedge clk_core) begin
        if (rst_core) seen <= '0;
        else          seen <= req_s;
    end

    for (genvar i = 0; i < NUM_REG; i++) begin : g_act
        localparam int G = grp_of_reg(i);
        always_ff @(posedge clk_core) begin
            if (rst_core)
                act_regs[i] <= '0;
            else if (take[G])
                act_regs[i] <= stg_regs[i];
        end
    end
endmodule

// File: rtl/cfg_shadow_loader.sv
module cfg_shadow_loader
    import cfgld_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_bus,
    input  logic                 rst_bus,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_GRP-1:0]   load_status,
    input  logic                 clk_core,
    input  logic                 rst_core,
    output logic                 act_pkt_mode,
    output logic                 act_new_fsm,
    output logic [DEB_W-1:0]     act_debounce,
    output logic                 act_multi_master,
    output logic [DIV_W-1:0]     act_div_hs,
    output logic [DIV_W-1:0]     act_div_std,
    output logic [DATA_W-1:0]    act_mst_cfg,
    output logic [DATA_W-1:0]    act_slv_cfg,
    output logic [DATA_W-1:0]    act_tmo_cfg
);
    logic [NUM_GRP-1:0]              req_tgl;
    logic [NUM_GRP-1:0]              req_s;
    logic [NUM_GRP-1:0]              ack_tgl;
    logic [NUM_GRP-1:0]              ack_s;
    logic [NUM_REG-1:0][DATA_W-1:0]  stg_regs;
    logic [NUM_REG-1:0][DATA_W-1:0]  act_regs;
    mst_fields_t                     mst_f;

    cfgld_bus_side u_bus (
        .clk_bus     (clk_bus),
        .rst_bus     (rst_bus),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ack_s       (ack_s),
        .req_tgl     (req_tgl),
        .load_status (load_status),
        .stg_regs    (stg_regs)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_cdc
        cfgld_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
            .clk (clk_core),
            .rst (rst_core),
            .d   (req_tgl[g]),
            .q   (req_s[g])
        );
        cfgld_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
            .clk (clk_bus),
            .rst (rst_bus),
            .d   (ack_tgl[g]),
            .q   (ack_s[g])
        );
    end

    cfgld_core_side u_core (
        .clk_core (clk_core),
        .rst_core (rst_core),
        .req_s    (req_s),
        .stg_regs (stg_regs),
        .act_regs (act_regs),
        .ack_tgl  (ack_tgl)
    );

    assign mst_f = decode_mst(act_regs[0], act_regs[1]);

    assign act_pkt_mode     = mst_f.pkt_mode;
    assign act_new_fsm      = mst_f.new_fsm;
    assign act_debounce     = mst_f.debounce;
    assign act_multi_master = mst_f.multi_master;
    assign act_div_hs       = mst_f.div_hs;
    assign act_div_std      = mst_f.div_std;
    assign act_mst_cfg      = act_regs[0];
    assign act_slv_cfg      = act_regs[2];
    assign act_tmo_cfg      = act_regs[3];
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker
    import cfgld_pkg::*;
(
    input logic                            clk_bus,
    input logic                            rst_bus,
    input logic                            clk_core,
    input logic                            rst_core,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic [NUM_GRP-1:0]              load_bits,
    input logic [NUM_GRP-1:0]              load_status,
    input logic [NUM_GRP-1:0]              req_tgl,
    input logic [NUM_GRP-1:0]              ack_tgl,
    input logic [NUM_REG-1:0][DATA_W-1:0]  stg_regs,
    input logic [NUM_REG-1:0][DATA_W-1:0]  act_regs
);
    logic load_wr;
    assign load_wr = wr_en && (wr_addr == ADDR_LOAD);

    p_reset_status_r1: assert property (@(posedge clk_bus)
        rst_bus |=> (load_status == '0));

    p_reset_active_r1: assert property (@(posedge clk_core)
        rst_core |=> (act_regs == '0));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        p_set_pending_r3: assert property (@(posedge clk_bus) disable iff (rst_bus)
            (load_wr && load_bits[g] && !load_status[g]) |=> load_status[g]);

        p_repeat_ignored_r6: assert property (@(posedge clk_bus) disable iff (rst_bus)
            (load_wr && load_status[g]) |=> $stable(req_tgl[g]));
    end

    for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
        localparam int G = grp_of_reg(i);

        p_stage_locked_r7: assert property (@(posedge clk_bus) disable iff (rst_bus)
            (wr_en && (wr_addr == ADDR_W'(i)) && load_status[G]) |=> $stable(stg_regs[i]));

        // R4, R5: active words move only on their own group's acknowledge edge
        p_atomic_update_r4: assert property (@(posedge clk_core) disable iff (rst_core)
            $stable(ack_tgl[G]) |-> $stable(act_regs[i]));
    end
endmodule

bind cfg_shadow_loader cfgld_checker chk_i (
    .clk_bus     (clk_bus),
    .rst_bus     (rst_bus),
    .clk_core    (clk_core),
    .rst_core    (rst_core),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .load_bits   (wr_data[cfgld_pkg::NUM_GRP-1:0]),
    .load_status (load_status),
    .req_tgl     (req_tgl),
    .ack_tgl     (ack_tgl),
    .stg_regs    (stg_regs),
    .act_regs    (act_regs)
);

// File: tb/cfg_shadow_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_shadow_loader_tb_top;
    import cfgld_pkg::*;

    logic               clk_bus = 1'b0;
    logic               clk_core = 1'b0;
    logic               rst_bus = 1'b1;
    logic               rst_core = 1'b1;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [NUM_GRP-1:0] load_status;
    logic               act_pkt_mode, act_new_fsm, act_multi_master;
    logic [DEB_W-1:0]   act_debounce;
    logic [DIV_W-1:0]   act_div_hs, act_div_std;
    logic [DATA_W-1:0]  act_mst_cfg, act_slv_cfg, act_tmo_cfg;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #4 clk_bus = ~clk_bus;
    always #6.5 clk_core = ~clk_core;

    cfg_shadow_loader dut_i (
        .clk_bus          (clk_bus),
        .rst_bus          (rst_bus),
        .wr_en            (wr_en),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .load_status      (load_status),
        .clk_core         (clk_core),
        .rst_core         (rst_core),
        .act_pkt_mode     (act_pkt_mode),
        .act_new_fsm      (act_new_fsm),
        .act_debounce     (act_debounce),
        .act_multi_master (act_multi_master),
        .act_div_hs       (act_div_hs),
        .act_div_std      (act_div_std),
        .act_mst_cfg      (act_mst_cfg),
        .act_slv_cfg      (act_slv_cfg),
        .act_tmo_cfg      (act_tmo_cfg)
    );

    typedef struct packed {
        logic [31:0] cfg;
        logic [31:0] div;
        logic        pkt;
        logic        fsm;
        logic [2:0]  deb;
        logic        mm;
        logic [15:0] hs;
        logic [15:0] std;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{cfg: 32'h0000_0400, div: 32'h0001_0003, pkt: 1'b1, fsm: 1'b0, deb: 3'd0, mm: 1'b0, hs: 16'h0003, std: 16'h0001},
        '{cfg: 32'h0002_2800, div: 32'h0019_0002, pkt: 1'b0, fsm: 1'b1, deb: 3'd2, mm: 1'b1, hs: 16'h0002, std: 16'h0019},
        '{cfg: 32'h0000_7C00, div: 32'hFFFF_0000, pkt: 1'b1, fsm: 1'b1, deb: 3'd7, mm: 1'b0, hs: 16'h0000, std: 16'hFFFF},
        '{cfg: 32'h0000_0000, div: 32'h1234_ABCD, pkt: 1'b0, fsm: 1'b0, deb: 3'd0, mm: 1'b0, hs: 16'hABCD, std: 16'h1234}
    };

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk_bus);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_idle(input string what, input logic [NUM_GRP-1:0] mask);
        int n = 0;
        while (((load_status & mask) != '0) && (n < 200)) begin
            @(negedge clk_bus);
            n++;
        end
        chk({what, " load clears by itself"}, 32'(load_status & mask), 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk_core);
        @(negedge clk_bus);
        rst_bus = 1'b0; rst_core = 1'b0;
        @(negedge clk_bus);

        // R1 reset state
        chk("R1 load_status", 32'(load_status), 32'd0);
        chk("R1 act_mst_cfg", act_mst_cfg, 32'd0);
        chk("R1 act_slv_cfg", act_slv_cfg, 32'd0);
        chk("R1 act_tmo_cfg", act_tmo_cfg, 32'd0);
        chk("R1 divisors", {act_div_std, act_div_hs}, 32'd0);

        // R2 staging alone changes nothing
        bus_write(3'd0, 32'h0002_2C00);
        bus_write(3'd2, 32'hA5A5_0001);
        repeat (40) @(negedge clk_bus);
        chk("R2 slave not loaded", act_slv_cfg, 32'd0);
        chk("R2 master not loaded", act_mst_cfg, 32'd0);

        // R3, R8 slave load round trip
        bus_write(ADDR_LOAD, 32'h2);
        chk("R3 slave pending", 32'(load_status), 32'h2);
        wait_idle("R3 slave", 3'b010);
        chk("R8 slave active at clear", act_slv_cfg, 32'hA5A5_0001);

        // R4 master vectors
        for (int k = 0; k < 4; k++) begin
            bus_write(3'd0, VEC[k].cfg);
            bus_write(3'd1, VEC[k].div);
            bus_write(ADDR_LOAD, 32'h1);
            chk("R3 master pending", 32'(load_status), 32'h1);
            wait_idle("R3 master", 3'b001);
            chk("R4 pkt_mode bit10", 32'(act_pkt_mode), 32'(VEC[k].pkt));
            chk("R4 new_fsm bit11", 32'(act_new_fsm), 32'(VEC[k].fsm));
            chk("R4 debounce bits14:12", 32'(act_debounce), 32'(VEC[k].deb));
            chk("R4 multi_master bit17", 32'(act_multi_master), 32'(VEC[k].mm));
            chk("R4 div_hs", 32'(act_div_hs), 32'(VEC[k].hs));
            chk("R4 div_std", 32'(act_div_std), 32'(VEC[k].std));
            chk("R8 raw master word", act_mst_cfg, VEC[k].cfg);
        end

        // R5 timeout alone leaves others untouched
        bus_write(3'd3, 32'h0000_0777);
        bus_write(ADDR_LOAD, 32'h4);
        wait_idle("R5 timeout", 3'b100);
        chk("R5 timeout loaded", act_tmo_cfg, 32'h0000_0777);
        chk("R5 slave unchanged", act_slv_cfg, 32'hA5A5_0001);
        chk("R5 divisor unchanged", {act_div_std, act_div_hs}, 32'h1234_ABCD);

        // R6 repeated 1 and written 0 while pending
        bus_write(3'd3, 32'h0000_0055);
        bus_write(ADDR_LOAD, 32'h4);
        bus_write(ADDR_LOAD, 32'h4);
        chk("R6 repeat load keeps pending", 32'(load_status), 32'h4);
        bus_write(ADDR_LOAD, 32'h0);
        chk("R6 zero write keeps pending", 32'(load_status), 32'h4);
        wait_idle("R6 timeout", 3'b100);
        chk("R6 timeout loaded once", act_tmo_cfg, 32'h0000_0055);
        bus_write(ADDR_LOAD, 32'h0);
        chk("R6 zero write while idle", 32'(load_status), 32'd0);

        // R7 staging write during pending is dropped
        bus_write(3'd3, 32'h0000_0066);
        bus_write(ADDR_LOAD, 32'h4);
        bus_write(3'd3, 32'h0000_0099);
        wait_idle("R7 timeout", 3'b100);
        chk("R7 staged value before load", act_tmo_cfg, 32'h0000_0066);
        bus_write(ADDR_LOAD, 32'h4);
        wait_idle("R7 reload", 3'b100);
        chk("R7 dropped write absent", act_tmo_cfg, 32'h0000_0066);

        // R5 two groups in one write
        bus_write(3'd2, 32'h0000_0011);
        bus_write(3'd3, 32'h0000_0022);
        bus_write(ADDR_LOAD, 32'h6);
        chk("R5 both pending", 32'(load_status), 32'h6);
        wait_idle("R5 pair", 3'b110);
        chk("R5 slave of pair", act_slv_cfg, 32'h0000_0011);
        chk("R5 timeout of pair", act_tmo_cfg, 32'h0000_0022);
        chk("R5 master untouched", act_mst_cfg, 32'h0000_0000);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule